// File: doc/BRIEF.md
# Memory Clock-Enable Power-State Sequencer

This block sits on the controller side of a synchronous DRAM. It owns the clock-enable line and the command bus while the memory moves into and out of its low-power modes. The host side raises a power-down request, a self-refresh request or a wake request. Two status inputs report whether any bank is open and whether a read, write, mode-register, precharge or refresh operation is still in flight. A third input reports that output-driver calibration is running. The block answers with the clock-enable level, a two-bit command, a mode code and two ready flags. The scheduler may resume normal traffic only when these flags allow it.

A power-down request becomes active power-down when a bank is open and precharge power-down when all banks are idle. Self-refresh is entered only with all banks idle. On the entry edge, clock-enable falls and the AUTOREFRESH command is issued on the same edge. Clock-enable holds each level for a minimum number of clocks. After a wake, the block holds NOP for a recovery window: a short one after power-down and a longer one after self-refresh. A separate, still longer window after self-refresh keeps reads blocked.

States: `ST_NORMAL`, `ST_SR_ENTRY`, `ST_PD_ACT`, `ST_PD_PRE`, `ST_SREF`, `ST_PD_EXIT`, `ST_SR_EXIT`. Transitions are as follows. `ST_NORMAL` goes to `ST_SR_ENTRY` on self-refresh entry, or to `ST_PD_ACT` or `ST_PD_PRE` on power-down entry. `ST_SR_ENTRY` always goes to `ST_SREF`. `ST_PD_ACT` and `ST_PD_PRE` go to `ST_PD_EXIT` on a wake. `ST_SREF` goes to `ST_SR_EXIT` on a wake. `ST_PD_EXIT` and `ST_SR_EXIT` return to `ST_NORMAL` when their window expires.

Top module: `cke_pwr_seq`

## Requirements
- R1: After reset, cke is 1, cmd is NOP (2'b00), lp_mode is 2'b00, and ready and rd_ready are both 1.
- R2: In normal state, a power-down request is accepted if the request line is high or a request is pending, busy and calib_active are low, wake_req is low and the high-width rule is met. On that edge cke falls and lp_mode becomes 2'b01 if banks_open is 1, or 2'b10 if banks_open is 0. ready drops on the same edge.
- R3: Once cke changes level, it keeps that level for at least MIN_W clock edges (default 3) before it may change again.
- R4: The cmd encoding is NOP = 2'b00, DESELECT = 2'b01, AUTOREFRESH = 2'b10. While cke is low, cmd is DESELECT except on the self-refresh entry cycle.
- R5: Self-refresh is entered only while banks_open is 0. On that edge cke falls, cmd is AUTOREFRESH for that one cycle and lp_mode becomes 2'b11. A self-refresh request made while a bank is open waits until banks_open drops.
- R6: A request that arrives while busy is high is held pending and is acted on at the first edge where busy is low.
- R7: After a wake from power-down, cke rises once the low width is met. cmd is NOP and ready stays low for PD_EXIT_CYC clocks (default 2) after cke rises; ready then returns to 1.
- R8: After a wake from self-refresh, cke rises once the low width is met. cmd stays NOP and ready stays low for SR_EXIT_CYC clocks (default 20) after cke rises.
- R9: rd_ready rises exactly RD_EXIT_CYC clocks (default 200) after cke rises on a self-refresh exit. Until then it stays low even though ready is high.
- R10: While calib_active is high, no low-power entry happens and any pending request is kept. In a low-power state, calib_active acts as a wake.
- R11: A wake_req in normal state cancels any pending low-power request.
- R12: Entry requests that arrive outside normal state are ignored and do not cause a later entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Request power-down entry |
| sr_req | input | 1 | Request self-refresh entry |
| wake_req | input | 1 | Request exit from low power; cancels pending entry in normal state |
| banks_open | input | 1 | At least one bank is open |
| busy | input | 1 | Read, write, mode-register, precharge or refresh still in progress |
| calib_active | input | 1 | Output-driver calibration running; clock-enable must stay high |
| cke | output | 1 | Clock-enable to the memory |
| cmd | output | 2 | Command: 00 NOP, 01 DESELECT, 10 AUTOREFRESH |
| lp_mode | output | 2 | 00 none, 01 active power-down, 10 precharge power-down, 11 self-refresh |
| ready | output | 1 | All exit windows expired; normal commands allowed |
| rd_ready | output | 1 | ready and the self-refresh read window expired |

## Verification
All outputs are decoded from registered state. A request, or a clearing of busy or calib_active, therefore shows on cke, cmd and lp_mode one edge after it is sampled. Once the low width is met, a wake raises cke on the third edge after the entry edge. ready follows the edge that raised cke by exactly the exit window length, and rd_ready follows it by exactly the read window. The bench drives inputs 2 ns after a rising edge and samples just before the next drive. It counts edges from the stimulus and checks each output on the cycle it is due and on the cycle before, so that both an early change and a late one are caught.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL   = 3'd0,
        ST_SR_ENTRY = 3'd1,
        ST_PD_ACT   = 3'd2,
        ST_PD_PRE   = 3'd3,
        ST_SREF     = 3'd4,
        ST_PD_EXIT  = 3'd5,
        ST_SR_EXIT  = 3'd6
    } pwr_state_t;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_DESEL = 2'b01,
        CMD_AREF  = 2'b10
    } bus_cmd_t;

    typedef enum logic [1:0] {
        LPM_NONE = 2'b00,
        LPM_APD  = 2'b01,
        LPM_PPD  = 2'b10,
        LPM_SREF = 2'b11
    } lp_mode_t;

    localparam int unsigned REQ_PD = 0;
    localparam int unsigned REQ_SR = 1;
    localparam int unsigned NUM_REQ = 2;

endpackage

// File: rtl/cke_width_track.sv
module cke_width_track #(
    parameter int unsigned MIN_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    output logic width_ok
);
    localparam int unsigned RW = $clog2(MIN_W + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(MIN_W);
    localparam logic [RW-1:0] RUN_OK  = RW'(MIN_W - 1);

    logic          lvl_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b1;
            run_q <= RUN_MAX;
        end else begin
            lvl_q <= cke;
            if (cke != lvl_q)
                run_q <= RW'(1);
            else if (run_q != RUN_MAX)
                run_q <= run_q + RW'(1);
        end
    end

    // level may change at this edge once it will have been sampled MIN_W times
    always_comb width_ok = (cke == lvl_q) && (run_q >= RUN_OK);

    AST_CKE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cke != lvl_q) |-> (run_q >= RUN_MAX)); // R3

endmodule

// File: rtl/cke_req_hold.sv
module cke_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic allow,
    input  logic take,
    input  logic cancel,
    output logic want
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (take || cancel)
            pend_q <= 1'b0;
        else if (req && allow)
            pend_q <= 1'b1;
    end

    always_comb want = pend_q || (req && allow);

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(take) |-> !pend_q); // R6

endmodule

// File: rtl/cke_exit_timer.sv
module cke_exit_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    always_comb done = (cnt_q == '0);

    AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - W'(1))); // R8

endmodule

// File: rtl/cke_pwr_seq.sv
module cke_pwr_seq
    import cke_pwr_pkg::*;
#(
    parameter int unsigned MIN_W       = 3,
    parameter int unsigned PD_EXIT_CYC = 2,
    parameter int unsigned SR_EXIT_CYC = 20,
    parameter int unsigned RD_EXIT_CYC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_req,
    input  logic       sr_req,
    input  logic       wake_req,
    input  logic       banks_open,
    input  logic       busy,
    input  logic       calib_active,
    output logic       cke,
    output logic [1:0] cmd,
    output logic [1:0] lp_mode,
    output logic       ready,
    output logic       rd_ready
);
    localparam int unsigned XMAX = (PD_EXIT_CYC > SR_EXIT_CYC) ? PD_EXIT_CYC : SR_EXIT_CYC;
    localparam int unsigned XW   = $clog2(XMAX + 1);
    localparam int unsigned RDW  = $clog2(RD_EXIT_CYC + 1);
    localparam logic [XW-1:0]  PD_LOAD = XW'(PD_EXIT_CYC - 1);
    localparam logic [XW-1:0]  SR_LOAD = XW'(SR_EXIT_CYC - 1);
    localparam logic [RDW-1:0] RD_LOAD = RDW'(RD_EXIT_CYC);

    pwr_state_t state_q, state_d;

    logic               width_ok;
    logic               in_normal;
    logic               go;
    logic               wake_any;
    logic [NUM_REQ-1:0] req_vec;
    logic [NUM_REQ-1:0] want;
    logic [NUM_REQ-1:0] take;
    logic               win_load;
    logic [XW-1:0]      win_val;
    logic               win_done;
    logic               rd_load;
    logic               rd_done;

    always_comb begin
        req_vec         = '0;
        req_vec[REQ_PD] = pd_req;
        req_vec[REQ_SR] = sr_req;
    end

    always_comb in_normal = (state_q == ST_NORMAL);
    always_comb go        = in_normal && !busy && !calib_active && !wake_req && width_ok;
    always_comb wake_any  = wake_req || calib_active;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
        cke_req_hold u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (req_vec[g]),
            .allow  (in_normal),
            .take   (take[g]),
            .cancel (in_normal && wake_req),
            .want   (want[g])
        );
    end

    cke_width_track #(.MIN_W(MIN_W)) u_width (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .width_ok (width_ok)
    );

    cke_exit_timer #(.W(XW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (win_val),
        .done     (win_done)
    );

    cke_exit_timer #(.W(RDW)) u_rdwin (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rd_load),
        .load_val (RD_LOAD),
        .done     (rd_done)
    );

    // next-state and transition strobes
    always_comb begin
        state_d  = state_q;
        take     = '0;
        win_load = 1'b0;
        win_val  = PD_LOAD;
        rd_load  = 1'b0;
        unique case (state_q)
            ST_NORMAL: begin
                if (go && want[REQ_SR] && !banks_open) begin
                    state_d      = ST_SR_ENTRY;
                    take[REQ_SR] = 1'b1;
                end else if (go && want[REQ_PD]) begin
                    state_d      = banks_open ? ST_PD_ACT : ST_PD_PRE;
                    take[REQ_PD] = 1'b1;
                end
            end
            ST_SR_ENTRY: state_d = ST_SREF;
            ST_PD_ACT, ST_PD_PRE: begin
                if (wake_any && width_ok) begin
                    state_d  = ST_PD_EXIT;
                    win_load = 1'b1;
                    win_val  = PD_LOAD;
                end
            end
            ST_SREF: begin
                if (wake_any && width_ok) begin
                    state_d  = ST_SR_EXIT;
                    win_load = 1'b1;
                    win_val  = SR_LOAD;
                    rd_load  = 1'b1;
                end
            end
            ST_PD_EXIT, ST_SR_EXIT: begin
                if (win_done) state_d = ST_NORMAL;
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    // outputs decoded from the state register
    always_comb begin
        cke     = 1'b1;
        cmd     = CMD_NOP;
        lp_mode = LPM_NONE;
        ready   = 1'b0;
        unique case (state_q)
            ST_NORMAL:   ready = 1'b1;
            ST_SR_ENTRY: begin cke = 1'b0; cmd = CMD_AREF;  lp_mode = LPM_SREF; end
            ST_PD_ACT:   begin cke = 1'b0; cmd = CMD_DESEL; lp_mode = LPM_APD;  end
            ST_PD_PRE:   begin cke = 1'b0; cmd = CMD_DESEL; lp_mode = LPM_PPD;  end
            ST_SREF:     begin cke = 1'b0; cmd = CMD_DESEL; lp_mode = LPM_SREF; end
            ST_PD_EXIT, ST_SR_EXIT: ;
            default: ;
        endcase
        rd_ready = ready && rd_done;
    end

    AST_LOW_NOT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cmd != CMD_NOP)); // R4
    AST_AREF_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_AREF) |-> (!cke && $past(cke))); // R5
    AST_SR_BANKS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_AREF) |-> !$past(banks_open)); // R5
    AST_NO_ENTRY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(cke)) |-> (!$past(busy) && !$past(calib_active))); // R6
    AST_READY_CKE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cke && lp_mode == LPM_NONE)); // R7
    AST_RD_READY_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> ready); // R9

endmodule

// File: tb/cke_pwr_seq_test.sv
module cke_pwr_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_req = 1'b0, sr_req = 1'b0, wake_req = 1'b0;
    logic       banks_open = 1'b0, busy = 1'b0, calib_active = 1'b0;
    logic       cke;
    logic [1:0] cmd;
    logic [1:0] lp_mode;
    logic       ready, rd_ready;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cke_pwr_seq uut (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .sr_req(sr_req),
        .wake_req(wake_req), .banks_open(banks_open), .busy(busy),
        .calib_active(calib_active), .cke(cke), .cmd(cmd),
        .lp_mode(lp_mode), .ready(ready), .rd_ready(rd_ready)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 400 && !ready; i++) tick();
    endtask

    task automatic wake_out();
        wake_req = 1'b1;
        idle(3);
        wake_req = 1'b0;
        wait_ready();
        idle(4);
    endtask

    task automatic t_reset();
        idle(2);
        check("R1 cke", cke, 1);
        check("R1 cmd", cmd, 0);
        check("R1 lp_mode", lp_mode, 0);
        check("R1 ready", ready, 1);
        check("R1 rd_ready", rd_ready, 1);
        rst_n = 1'b1;
        idle(4);
    endtask

    task automatic t_active_pd();
        banks_open = 1'b1;
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        check("R2 apd cke", cke, 0);
        check("R2 apd mode", lp_mode, 1);
        check("R2 apd ready", ready, 0);
        check("R4 apd cmd", cmd, 1);
        wake_req = 1'b1;
        tick();
        tick();
        check("R3 low width held", cke, 0);
        tick();
        check("R3 exit after width", cke, 1);
        check("R7 exit cmd", cmd, 0);
        wake_req = 1'b0;
        tick();
        check("R7 ready early", ready, 0);
        tick();
        check("R7 ready due", ready, 1);
        idle(4);
    endtask

    task automatic t_precharge_pd_ignore();
        banks_open = 1'b0;
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        check("R2 ppd mode", lp_mode, 2);
        sr_req = 1'b1;
        tick();
        sr_req = 1'b0;
        wake_out();
        begin
            int lows = 0;
            for (int i = 0; i < 8; i++) begin
                tick();
                if (!cke) lows++;
            end
            check("R12 no late entry", lows, 0);
        end
    endtask

    task automatic t_busy_hold();
        banks_open = 1'b1;
        busy = 1'b1;
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        check("R6 busy blocks", cke, 1);
        idle(3);
        check("R6 still blocked", cke, 1);
        busy = 1'b0;
        tick();
        check("R6 pending taken", cke, 0);
        check("R6 mode", lp_mode, 1);
        wake_out();
    endtask

    task automatic t_calib();
        banks_open = 1'b0;
        calib_active = 1'b1;
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        check("R10 calib blocks", cke, 1);
        tick();
        calib_active = 1'b0;
        tick();
        check("R10 pending kept", cke, 0);
        calib_active = 1'b1;
        idle(2);
        check("R10 low width", cke, 0);
        tick();
        check("R10 calib wakes", cke, 1);
        calib_active = 1'b0;
        wait_ready();
        idle(4);
    endtask

    task automatic t_cancel();
        busy = 1'b1;
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        wake_req = 1'b1;
        tick();
        wake_req = 1'b0;
        busy = 1'b0;
        begin
            int lows = 0;
            for (int i = 0; i < 4; i++) begin
                tick();
                if (!cke) lows++;
            end
            check("R11 cancelled", lows, 0);
        end
    endtask

    task automatic t_sr_banks();
        banks_open = 1'b1;
        sr_req = 1'b1;
        tick();
        sr_req = 1'b0;
        check("R5 banks open blocks", cke, 1);
        idle(2);
        check("R5 still waiting", lp_mode, 0);
        banks_open = 1'b0;
        tick();
        check("R5 entry cke", cke, 0);
        check("R5 entry aref", cmd, 2);
        check("R5 entry mode", lp_mode, 3);
        wake_out();
    endtask

    task automatic t_sr_exit();
        banks_open = 1'b0;
        sr_req = 1'b1;
        tick();
        sr_req = 1'b0;
        check("R5 aref", cmd, 2);
        wake_req = 1'b1;
        tick();
        check("R4 sref cmd", cmd, 1);
        tick();
        tick();
        check("R8 cke up", cke, 1);
        check("R8 nop", cmd, 0);
        wake_req = 1'b0;
        idle(19);
        check("R8 ready early", ready, 0);
        tick();
        check("R8 ready due", ready, 1);
        check("R9 rd blocked", rd_ready, 0);
        idle(179);
        check("R9 rd early", rd_ready, 0);
        tick();
        check("R9 rd due", rd_ready, 1);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #3;
        t_reset();
        t_active_pd();
        t_precharge_pd_ignore();
        t_busy_hold();
        t_calib();
        t_cancel();
        t_sr_banks();
        t_sr_exit();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule